// File: doc/BRIEF.md
# Two-Bank Multi-Grant Load/Store Request Picker

This block takes up to sixteen pending load/store requests each cycle and chooses which of them reach a pair of cache-side banks. One address bit decides the bank for each request. Each bank has its own picker, which grants up to four requests in the same cycle, so eight requests can be served per cycle without a dual-ported cache array. Each bank port is sixteen bytes wide.

Each bank output port carries a one-hot vector that names the granted request index, and a valid flag. A static configuration input can demote misaligned requests behind every aligned request in the same bank. Within a class, the lower request index wins. An optional register stage, selected by a parameter, retimes all outputs.

Top module: `lsq_bank_picker`

## Requirements
- R1: A valid request whose address bit 4 (parameter BANK_BIT) is 0 may only be granted on the even bank. A valid request whose bit 4 is 1 may only be granted on the odd bank. No other address bit affects any grant.
- R2: Each grant vector is zero or one-hot, and only names requests whose request-valid bit is 1. Bit i of port p's vector, at bits [p*16+i], selects request i.
- R3: No request is granted on more than one port, and no request is granted in both banks in the same cycle.
- R4: With demotion off, each bank grants its valid requests in ascending index order. Port 0 takes the lowest index, port 1 the next, and so on up to port 3.
- R5: The port valid flags fill from port 0 upwards. A port whose valid flag is 0 carries an all-zero grant vector.
- R6: With demote_en_i = 1, a request whose aligned flag is 1 is aligned and one whose flag is 0 is misaligned. In each bank, every aligned request is placed ahead of every misaligned one. Within each class, ascending index order still applies.
- R7: With demote_en_i = 0, the aligned flags have no effect on any output.
- R8: If a bank has k valid requests, exactly min(k, 4) of its port valid flags are 1.
- R9: With OUT_REG = 1 (the default), all outputs are zero while rst_ni is low, and they reflect the inputs one clock edge later. With OUT_REG = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| demote_en_i | input | 1 | Static enable: misaligned requests go behind aligned ones |
| req_valid_i | input | 16 | Request-valid bit per request |
| req_addr_i | input | 16*32 | Request addresses; request i at bits [i*32 +: 32] |
| req_aligned_i | input | 16 | 1 = request is aligned |
| even_gnt_o | output | 4*16 | Even bank one-hot grants; port p at [p*16 +: 16] |
| even_vld_o | output | 4 | Even bank port valid flags |
| odd_gnt_o | output | 4*16 | Odd bank one-hot grants; port p at [p*16 +: 16] |
| odd_vld_o | output | 4 | Odd bank port valid flags |

## Verification
The assertions check structural properties on every cycle. The banks never share a request. Grants are one-hot and lie inside the request set. Ports never double-grant. Port indices rise from port to port. Valid flags fill from port 0 with no gaps. A bank with four or more requests fills every port. No misaligned grant is made while an aligned request is left waiting under demotion. The register stage tracks its input one cycle later. The bench scenarios cover the rest, by comparing outputs against an independent model: the exact choice and ordering of indices, that address bits other than the bank bit have no effect, that aligned flags are ignored when demotion is off, the reset value, and the one-cycle latency set against the combinational variant.

// File: rtl/lsq_pick_pkg.sv
package lsq_pick_pkg;
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/lsq_bank_steer.sv
module lsq_bank_steer
  import lsq_pick_pkg::*;
#(
  parameter int N_REQ    = 16,
  parameter int ADDR_W   = 32,
  parameter int BANK_BIT = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_valid_i,
  input  logic [N_REQ*ADDR_W-1:0]       req_addr_i,
  output logic [NUM_BANKS-1:0][N_REQ-1:0] bank_req_o
);
  logic unused_addr;
  assign unused_addr = ^req_addr_i;

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    logic sel;
    assign sel = req_addr_i[i*ADDR_W+BANK_BIT];
    assign bank_req_o[BANK_EVEN][i] = req_valid_i[i] & ~sel;
    assign bank_req_o[BANK_ODD][i]  = req_valid_i[i] &  sel;
  end

  // R3
  bank_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_req_o[BANK_EVEN] & bank_req_o[BANK_ODD]) == '0);
  // R1
  bank_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_req_o[BANK_EVEN] | bank_req_o[BANK_ODD]) == req_valid_i);
endmodule

// File: rtl/lsq_multi_pick.sv
module lsq_multi_pick #(
  parameter int W = 32,
  parameter int P = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   req_i,
  output logic [P*W-1:0] gnt_o,
  output logic [P-1:0]   vld_o
);
  logic [P-1:0][W-1:0] rem;
  assign rem[0] = req_i;

  for (genvar p = 0; p < P; p++) begin : g_port
    logic [W-1:0] one;
    // isolate lowest set bit of what is left
    assign one = rem[p] & (~rem[p] + W'(1));
    assign gnt_o[p*W +: W] = one;
    assign vld_o[p] = |rem[p];
    if (p < P-1) begin : g_next
      assign rem[p+1] = rem[p] & ~one;
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o[p*W +: W]));
    // R2
    gnt_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[p*W +: W] & ~req_i) == '0);
    // R5
    vld_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o[p] == (gnt_o[p*W +: W] != '0));
    if (p > 0) begin : g_ord
      // R5
      vld_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o[p] |-> vld_o[p-1]);
      // R4
      gnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o[p] |-> (gnt_o[p*W +: W] > gnt_o[(p-1)*W +: W]));
      // R3
      gnt_nodup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o[p*W +: W] & gnt_o[(p-1)*W +: W]) == '0);
    end
  end

  // R8
  fill_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(req_i) >= P) |-> (vld_o == '1));
endmodule

// File: rtl/lsq_bank_pick.sv
module lsq_bank_pick #(
  parameter int N_REQ = 16,
  parameter int P     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             demote_en_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] aligned_i,
  output logic [P*N_REQ-1:0] gnt_o,
  output logic [P-1:0]     vld_o
);
  localparam int W = 2 * N_REQ;

  logic [W-1:0]   prio;
  logic [P*W-1:0] wide_gnt;
  logic [N_REQ-1:0] any_gnt;

  // upper half holds the demoted class
  always_comb begin
    if (demote_en_i) prio = {req_i & ~aligned_i, req_i & aligned_i};
    else             prio = {{N_REQ{1'b0}}, req_i};
  end

  lsq_multi_pick #(.W(W), .P(P)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (prio),
    .gnt_o  (wide_gnt),
    .vld_o  (vld_o)
  );

  for (genvar p = 0; p < P; p++) begin : g_fold
    assign gnt_o[p*N_REQ +: N_REQ] = wide_gnt[p*W +: N_REQ] | wide_gnt[p*W+N_REQ +: N_REQ];
  end

  always_comb begin
    any_gnt = '0;
    for (int p = 0; p < P; p++) any_gnt |= gnt_o[p*N_REQ +: N_REQ];
  end

  // R6
  demote_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demote_en_i && ((any_gnt & ~aligned_i) != '0)) |->
      ((req_i & aligned_i & ~any_gnt) == '0));
  // R2
  fold_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_gnt & ~req_i) == '0);
endmodule

// File: rtl/lsq_out_stage.sv
module lsq_out_stage #(
  parameter int W       = 136,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
    // R9
    reg_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (q_o == $past(d_i)));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/lsq_bank_picker.sv
module lsq_bank_picker
  import lsq_pick_pkg::*;
#(
  parameter int N_REQ    = 16,
  parameter int ADDR_W   = 32,
  parameter int BANK_BIT = 4,
  parameter int N_PORTS  = 4,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      demote_en_i,
  input  logic [N_REQ-1:0]          req_valid_i,
  input  logic [N_REQ*ADDR_W-1:0]   req_addr_i,
  input  logic [N_REQ-1:0]          req_aligned_i,
  output logic [N_PORTS*N_REQ-1:0]  even_gnt_o,
  output logic [N_PORTS-1:0]        even_vld_o,
  output logic [N_PORTS*N_REQ-1:0]  odd_gnt_o,
  output logic [N_PORTS-1:0]        odd_vld_o
);
  localparam int GW    = N_PORTS * N_REQ;
  localparam int BW    = GW + N_PORTS;
  localparam int OUT_W = NUM_BANKS * BW;

  logic [NUM_BANKS-1:0][N_REQ-1:0] bank_req;
  logic [NUM_BANKS-1:0][GW-1:0]    gnt;
  logic [NUM_BANKS-1:0][N_PORTS-1:0] vld;
  logic [OUT_W-1:0] comb_out, reg_out;

  lsq_bank_steer #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) u_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .bank_req_o  (bank_req)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lsq_bank_pick #(.N_REQ(N_REQ), .P(N_PORTS)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .demote_en_i (demote_en_i),
      .req_i       (bank_req[b]),
      .aligned_i   (req_aligned_i),
      .gnt_o       (gnt[b]),
      .vld_o       (vld[b])
    );
    assign comb_out[b*BW +: BW] = {vld[b], gnt[b]};
  end

  lsq_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (comb_out),
    .q_o    (reg_out)
  );

  assign {even_vld_o, even_gnt_o} = reg_out[BANK_EVEN*BW +: BW];
  assign {odd_vld_o,  odd_gnt_o}  = reg_out[BANK_ODD*BW  +: BW];
endmodule

// File: tb/sim_lsq_bank_picker.sv
`timescale 1ns/1ps
module sim_lsq_bank_picker;
  localparam int N  = 16;
  localparam int AW = 32;
  localparam int P  = 4;
  localparam int NV = 8;

  typedef struct packed {
    logic [15:0] v;
    logic [15:0] bank;
    logic [15:0] al;
    logic        dm;
    logic [3:0]  ev;
    logic [3:0]  ov;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, 4'hF, 4'h0},
    '{16'hFFFF, 16'hAAAA, 16'hFFFF, 1'b0, 4'hF, 4'hF},
    '{16'h0001, 16'h0000, 16'h0001, 1'b0, 4'h1, 4'h0},
    '{16'h8003, 16'h8000, 16'h0000, 1'b1, 4'h3, 4'h1},
    '{16'h00F0, 16'h0000, 16'h00C0, 1'b1, 4'hF, 4'h0},
    '{16'h0000, 16'h0000, 16'h0000, 1'b0, 4'h0, 4'h0},
    '{16'hF00F, 16'hF000, 16'hA00A, 1'b1, 4'hF, 4'hF},
    '{16'h0E00, 16'h0E00, 16'h0000, 1'b0, 4'h0, 4'h7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dm;
  logic [N-1:0] rv, ral;
  logic [N*AW-1:0] raddr;
  logic [P*N-1:0] eg0, og0, eg1, og1;
  logic [P-1:0] ev0, ov0, ev1, ov1;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lsq_bank_picker u0 (
    .clk_i(clk), .rst_ni(rst_n), .demote_en_i(dm), .req_valid_i(rv),
    .req_addr_i(raddr), .req_aligned_i(ral),
    .even_gnt_o(eg0), .even_vld_o(ev0), .odd_gnt_o(og0), .odd_vld_o(ov0)
  );

  lsq_bank_picker #(.OUT_REG(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .demote_en_i(dm), .req_valid_i(rv),
    .req_addr_i(raddr), .req_aligned_i(ral),
    .even_gnt_o(eg1), .even_vld_o(ev1), .odd_gnt_o(og1), .odd_vld_o(ov1)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent model: per bank, walk classes then indices
  task automatic model(input logic [15:0] v, input logic [15:0] bank, input logic [15:0] al,
                       input logic d, input int b,
                       output logic [63:0] g, output logic [3:0] vl);
    int cnt = 0;
    g = '0;
    vl = '0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < N; i++) begin
        logic take;
        take = d ? ((pass == 0) ? al[i] : !al[i]) : (pass == 0);
        if (v[i] && (int'(bank[i]) == b) && take && cnt < P) begin
          g[cnt*N+i] = 1'b1;
          vl[cnt] = 1'b1;
          cnt++;
        end
      end
    end
  endtask

  task automatic drive(input logic [15:0] v, input logic [15:0] bank, input logic [15:0] al,
                       input logic d, input logic [31:0] salt);
    @(negedge clk);
    rv = v;
    ral = al;
    dm = d;
    for (int i = 0; i < N; i++) begin
      logic [31:0] a;
      a = (32'h9E37_79B9 ^ salt) * 32'(i + 1);
      a[4] = bank[i];
      raddr[i*AW +: AW] = a;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] xg, yg;
    logic [3:0] xv, yv;
    rv = '0; ral = '0; dm = 1'b0; raddr = '0;
    // R9 reset state with live requests
    drive(16'hFFFF, 16'h00FF, 16'hFFFF, 1'b0, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 reset even", {eg0, ev0}, '0);
    chk("R9 reset odd", {og0, ov0}, '0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].v, VECS[k].bank, VECS[k].al, VECS[k].dm, 32'(k * 7919));
      @(posedge clk); @(negedge clk);
      model(VECS[k].v, VECS[k].bank, VECS[k].al, VECS[k].dm, 0, xg, xv);
      model(VECS[k].v, VECS[k].bank, VECS[k].al, VECS[k].dm, 1, yg, yv);
      chk("R1 R4 R6 even grants", eg0, xg);
      chk("R1 R4 R6 odd grants", og0, yg);
      chk("R8 even valid", 64'(ev0), 64'(VECS[k].ev));
      chk("R8 odd valid", 64'(ov0), 64'(VECS[k].ov));
      chk("R5 R9 comb even", {eg1, ev1}, {xg, xv});
      chk("R5 R9 comb odd", {og1, ov1}, {yg, yv});
      chk("R3 port disjoint", 64'($countones(eg0[15:0] | eg0[31:16] | eg0[47:32] | eg0[63:48])),
          64'($countones(ev0)));
    end

    // R4 explicit port order, interleaved banks
    drive(16'hFFFF, 16'hAAAA, 16'h0000, 1'b0, 32'h55);
    @(posedge clk); @(negedge clk);
    chk("R4 even port0", 64'(eg0[15:0]), 64'h0001);
    chk("R4 even port3", 64'(eg0[63:48]), 64'h0040);
    chk("R4 odd port0", 64'(og0[15:0]), 64'h0002);

    // R6 aligned 6,7 ahead of 4,5
    drive(16'h00F0, 16'h0000, 16'h00C0, 1'b1, 32'h77);
    @(posedge clk); @(negedge clk);
    chk("R6 port0 aligned", 64'(eg0[15:0]), 64'h0040);
    chk("R6 port2 misaligned", 64'(eg0[47:32]), 64'h0010);

    // R7 aligned flags ignored when demotion off
    drive(16'h0F3C, 16'h0300, 16'h0000, 1'b0, 32'h9);
    #1 xg = eg1; xv = ev1; yg = og1; yv = ov1;
    drive(16'h0F3C, 16'h0300, 16'h0A5C, 1'b0, 32'h9);
    #1;
    chk("R7 even unchanged", {eg1, ev1}, {xg, xv});
    chk("R7 odd unchanged", {og1, ov1}, {yg, yv});

    // R1 only bank bit matters: other address bits changed
    drive(16'h0F3C, 16'h0300, 16'h0000, 1'b0, 32'hDEAD_BEEF);
    #1;
    chk("R1 addr bits ignored", {eg1, ev1, og1, ov1}, {xg, xv, yg, yv});

    // R9 latency: registered copy holds previous until the edge
    @(posedge clk); @(negedge clk);
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 32'h0);
    #1;
    chk("R9 comb follows", 64'(ev1), 64'h0);
    chk("R9 reg holds", {eg0, ev0}, {xg, xv});
    @(posedge clk); @(negedge clk);
    chk("R9 reg updates", 64'(ev0), 64'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule